// File: doc/BRIEF.md
# Serial Master Transfer Sequencer

This block is the command sequencer that sits between a software-visible control register and the bit-level engine of a serial bus master. Software programs a byte count and then writes a control word. When that word enables the block, selects master operation, keeps 7-bit addressing and sets the start bit, the sequencer walks through an address phase, a run of byte transfers and an optional stop. It issues one command at a time and waits for the engine's one-cycle completion pulse and acknowledge result before it takes the next step.

As it runs, the sequencer keeps the control word current. The start bit clears once the address phase ends. The stop bit clears after a stop has gone out, or when the address is not acknowledged. The master bit clears when a transfer finishes without a stop. It also maintains four status flags: no-acknowledge, access-ready, receive-ready and transmit-ready. A control word that asks for slave mode or 10-bit addressing while enabled is refused. A parameter chooses between the legacy and newer revisions, which differ in how reset is requested by software and in whether status flags can be cleared by software.

Top module: `smt_seq`

## Requirements
- R1: A control write (register select 0) accepted while idle stores the written word ANDed with 0xcf87. The bit meanings are: bit 15 enable, bit 10 master, bit 9 transmit direction, bit 8 extended address, bit 1 stop, bit 0 start.
- R2: `sys_status` always shows the stored enable bit (control bit 15).
- R3: A control write with enable set and either master clear or extended address set is stored, but no command is issued. `cfg_reject` pulses high for the one cycle after the write edge.
- R4: A control write with enable, master and start set and extended address clear issues a start command (`cmd_op` 1). `cmd_rd` is the inverse of the direction bit. The command stays asserted until `eng_done`, and the start bit is clear after that completion whatever the acknowledge result.
- R5: If the address phase completes with `eng_ack` low, status bit 1 (no-acknowledge) is set, the stop bit clears, no byte command follows and the sequencer returns to idle.
- R6: If the address phase is acknowledged, exactly as many byte commands (`cmd_op` 2) follow as the programmed count (register select 1). In transmit direction a byte command is offered only while `tx_avail` is high. In receive direction the byte acknowledge is ignored. A count of zero means no byte commands.
- R7: When the count is used up and the stop bit is set, a stop command (`cmd_op` 3) is issued. After it completes, the stop bit is clear and `txbuf_clr` pulses for exactly one cycle.
- R8: When the count is used up and the stop bit is clear, status bit 2 (access-ready) is set, control bit 10 (master) clears and no stop command is issued.
- R9: In transmit direction, status bit 4 (transmit-ready) is high after each acknowledged step that leaves bytes still to send, and low once the count is used up. A byte that is not acknowledged clears it, sets status bit 1 and ends the transfer with no stop command.
- R10: Status bit 3 (receive-ready) follows `rx_nonempty` one cycle later while the direction bit is clear, and is 0 while the direction bit is set.
- R11: In the legacy revision a control write with enable clear resets the control word, the count and all status. In the newer revision the same write is simply stored.
- R12: In the newer revision, writing data bit 1 to the system-config register (select 3) resets the block, and writing the status register (select 2) clears status bits 1 and 2 where the data bit is 1. A hardware set in the same cycle wins over the clear. In the legacy revision both writes have no effect.
- R13: Control writes that arrive while a transfer is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count, 2 status, 3 system-config |
| wr_data | input | 16 | Write data |
| eng_done | input | 1 | One-cycle completion pulse from the bus engine |
| eng_ack | input | 1 | Acknowledge result, valid with `eng_done` |
| tx_avail | input | 1 | Transmit data is available for the next byte |
| rx_nonempty | input | 1 | Receive buffer holds at least one byte |
| ctrl_q | output | 16 | Stored control word |
| stat_q | output | 16 | Status: bit 1 no-ack, bit 2 access-ready, bit 3 rx-ready, bit 4 tx-ready |
| sys_status | output | 1 | Enable bit readback |
| cfg_reject | output | 1 | Pulse: refused control word |
| cmd_valid | output | 1 | Command to the engine is pending |
| cmd_op | output | 2 | Command code: 1 start, 2 byte, 3 stop |
| cmd_rd | output | 1 | Read direction of the transfer |
| txbuf_clr | output | 1 | Pulse: empty the transmit buffer |

## Verification
Two things can touch the same status flag on one edge: the hardware setting access-ready or no-acknowledge when a step completes, and a software write-one-to-clear of that flag. The bench provokes this by putting a status write on the very clock edge where the engine reports the final byte done, or reports a refused address. It then expects the flag to read as set. A separate write afterwards must clear the flag, which shows that the earlier clear was overridden by the set and did not simply go missing.

// File: rtl/smt_pkg.sv
// Shared definitions for the serial master transfer sequencer.
// Assumes a 16-bit register data path; bit positions match the control word.
package smt_pkg;
    localparam int unsigned DATA_W = 16;
    localparam logic [DATA_W-1:0] CTRL_MASK = 16'hcf87;

    localparam int unsigned B_EN  = 15;
    localparam int unsigned B_MST = 10;
    localparam int unsigned B_TRX = 9;
    localparam int unsigned B_XA  = 8;
    localparam int unsigned B_STP = 1;
    localparam int unsigned B_STT = 0;

    localparam int unsigned S_NACK = 1;
    localparam int unsigned S_ARDY = 2;
    localparam int unsigned S_RRDY = 3;
    localparam int unsigned S_XRDY = 4;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_START = 2'd1,
        OP_BYTE  = 2'd2,
        OP_STOP  = 2'd3
    } smt_op_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_STAT  = 2'd2,
        RA_SYSC  = 2'd3
    } smt_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_STOP = 2'd3
    } smt_state_e;
endpackage

// File: rtl/smt_ctrl.sv
// Control word and byte count registers.
// Decodes software writes into a transfer launch, a refusal or a soft reset.
// Assumes the sequencer reports busy so that control writes mid-transfer are dropped.
module smt_ctrl
    import smt_pkg::*;
#(
    parameter bit          NEWER_REV = 1'b1,
    parameter int unsigned CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              clr_start,
    input  logic              clr_stop,
    input  logic              clr_master,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              launch,
    output logic              cfg_reject,
    output logic              soft_rst
);
    logic sel_ctrl, sel_count, sel_sysc;
    logic ctrl_wr, refused;

    // Decode the write strobes by register select
    always_comb begin
        sel_ctrl  = wr_en && (wr_addr == RA_CTRL);
        sel_count = wr_en && (wr_addr == RA_COUNT);
        sel_sysc  = wr_en && (wr_addr == RA_SYSC);
    end

    // Pick the software reset request that belongs to this revision
    generate
        if (NEWER_REV) begin : g_rst_new
            assign soft_rst = sel_sysc && wr_data[1];
        end else begin : g_rst_old
            assign soft_rst = sel_ctrl && !busy && !wr_data[B_EN];
        end
    endgenerate

    // Classify an accepted control write as launch, refusal or plain store
    always_comb begin
        ctrl_wr = sel_ctrl && !busy && !soft_rst;
        refused = ctrl_wr && wr_data[B_EN] && (!wr_data[B_MST] || wr_data[B_XA]);
        launch  = ctrl_wr && wr_data[B_EN] && wr_data[B_MST] && !wr_data[B_XA]
                  && wr_data[B_STT];
    end

    // Hold the control word and apply the sequencer's self-clears
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data & CTRL_MASK;
        end else begin
            if (clr_start)  ctrl_q[B_STT] <= 1'b0;
            if (clr_stop)   ctrl_q[B_STP] <= 1'b0;
            if (clr_master) ctrl_q[B_MST] <= 1'b0;
        end
    end

    // Hold the programmed byte count
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            count_q <= '0;
        end else if (sel_count) begin
            count_q <= wr_data[CNT_W-1:0];
        end
    end

    // Flag a refused control word for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= refused;
        end
    end
endmodule

// File: rtl/smt_fsm.sv
// Transfer state machine: address, byte run and optional stop.
// Issues one command at a time and advances only on the engine's done pulse.
// Assumes eng_ack is valid whenever eng_done is high.
module smt_fsm
    import smt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             launch,
    input  logic             trx,
    input  logic             stop_bit,
    input  logic [CNT_W-1:0] count_q,
    input  logic             eng_done,
    input  logic             eng_ack,
    input  logic             tx_avail,
    output logic             busy,
    output logic             cmd_valid,
    output smt_op_e          cmd_op,
    output logic             cmd_rd,
    output logic             clr_start,
    output logic             clr_stop,
    output logic             clr_master,
    output logic             ev_nack,
    output logic             ev_ardy,
    output logic             xrdy_wr,
    output logic             xrdy_val,
    output logic             txbuf_clr
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    smt_state_e       state;
    logic [CNT_W-1:0] work_cnt;
    logic fire, addr_nack, byte_nack, finish;

    // Command presented to the engine in each state
    always_comb begin
        busy      = (state != ST_IDLE);
        cmd_rd    = !trx;
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        case (state)
            ST_ADDR: begin cmd_valid = 1'b1; cmd_op = OP_START; end
            ST_DATA: begin cmd_valid = !trx || tx_avail; cmd_op = OP_BYTE; end
            ST_STOP: begin cmd_valid = 1'b1; cmd_op = OP_STOP; end
            default: ;
        endcase
    end

    // Outcome of the step that completes this cycle
    always_comb begin
        fire      = cmd_valid && eng_done;
        addr_nack = fire && (state == ST_ADDR) && !eng_ack;
        byte_nack = fire && (state == ST_DATA) && trx && !eng_ack;
        finish    = fire && (((state == ST_ADDR) && eng_ack && (count_q == '0)) ||
                             ((state == ST_DATA) && !byte_nack && (work_cnt == ONE)));
        clr_start  = fire && (state == ST_ADDR);
        clr_stop   = addr_nack || (fire && (state == ST_STOP));
        clr_master = finish && !stop_bit;
        ev_ardy    = finish && !stop_bit;
        ev_nack    = addr_nack || byte_nack;
        xrdy_wr    = fire && trx && ((state == ST_ADDR) || (state == ST_DATA));
        xrdy_val   = eng_ack && ((state == ST_ADDR) ? (count_q != '0) : (work_cnt != ONE));
    end

    // Advance the state and the working byte count
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state    <= ST_IDLE;
            work_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) state <= ST_ADDR;
                ST_ADDR: if (fire) begin
                    work_cnt <= count_q;
                    if (addr_nack)   state <= ST_IDLE;
                    else if (finish) state <= stop_bit ? ST_STOP : ST_IDLE;
                    else             state <= ST_DATA;
                end
                ST_DATA: if (fire) begin
                    work_cnt <= work_cnt - ONE;
                    if (byte_nack)   state <= ST_IDLE;
                    else if (finish) state <= stop_bit ? ST_STOP : ST_IDLE;
                end
                ST_STOP: if (fire) begin
                    work_cnt <= count_q;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle request to empty the transmit buffer after a stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_clr <= 1'b0;
        end else begin
            txbuf_clr <= fire && (state == ST_STOP);
        end
    end
endmodule

// File: rtl/smt_status.sv
// Status flags: no-acknowledge, access-ready, receive-ready, transmit-ready.
// Hardware sets take priority over a software clear in the same cycle.
// Assumes the software clear strobe is already qualified by register select.
module smt_status
    import smt_pkg::*;
#(
    parameter bit NEWER_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stat_wr,
    input  logic [1:0]        clr_bits,
    input  logic              ev_nack,
    input  logic              ev_ardy,
    input  logic              xrdy_wr,
    input  logic              xrdy_val,
    input  logic              trx,
    input  logic              rx_nonempty,
    output logic [DATA_W-1:0] stat_q
);
    logic nack_q, ardy_q, rrdy_q, xrdy_q;
    logic clr_nack, clr_ardy;

    // Software clears exist only in the newer revision
    generate
        if (NEWER_REV) begin : g_w1c
            assign clr_nack = stat_wr && clr_bits[0];
            assign clr_ardy = stat_wr && clr_bits[1];
        end else begin : g_no_w1c
            assign clr_nack = 1'b0;
            assign clr_ardy = 1'b0;
        end
    endgenerate

    // Sticky flags with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            nack_q <= 1'b0;
            ardy_q <= 1'b0;
        end else begin
            if (ev_nack)       nack_q <= 1'b1;
            else if (clr_nack) nack_q <= 1'b0;
            if (ev_ardy)       ardy_q <= 1'b1;
            else if (clr_ardy) ardy_q <= 1'b0;
        end
    end

    // Ready flags driven by hardware only
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rrdy_q <= 1'b0;
            xrdy_q <= 1'b0;
        end else begin
            rrdy_q <= !trx && rx_nonempty;
            if (xrdy_wr) xrdy_q <= xrdy_val;
        end
    end

    // Assemble the status word
    always_comb begin
        stat_q         = '0;
        stat_q[S_NACK] = nack_q;
        stat_q[S_ARDY] = ardy_q;
        stat_q[S_RRDY] = rrdy_q;
        stat_q[S_XRDY] = xrdy_q;
    end
endmodule

// File: rtl/smt_seq.sv
// Top of the serial master transfer sequencer.
// Joins the register decode, the state machine and the status flags.
// Assumes a single-cycle write strobe and a bus engine with a done pulse.
module smt_seq
    import smt_pkg::*;
#(
    parameter bit          NEWER_REV = 1'b1,
    parameter int unsigned CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        eng_done,
    input  logic        eng_ack,
    input  logic        tx_avail,
    input  logic        rx_nonempty,
    output logic [15:0] ctrl_q,
    output logic [15:0] stat_q,
    output logic        sys_status,
    output logic        cfg_reject,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic        cmd_rd,
    output logic        txbuf_clr
);
    logic [CNT_W-1:0] count_q;
    logic launch, soft_rst, busy;
    logic clr_start, clr_stop, clr_master;
    logic ev_nack, ev_ardy, xrdy_wr, xrdy_val;
    logic stat_wr;
    smt_op_e op_e;

    // Status-register write strobe
    assign stat_wr    = wr_en && (wr_addr == RA_STAT);
    // Enable readback for the system-status register
    assign sys_status = ctrl_q[B_EN];
    // Command code onto the plain port
    assign cmd_op     = op_e;

    smt_ctrl #(.NEWER_REV(NEWER_REV), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .clr_start(clr_start),
        .clr_stop(clr_stop), .clr_master(clr_master), .ctrl_q(ctrl_q),
        .count_q(count_q), .launch(launch), .cfg_reject(cfg_reject),
        .soft_rst(soft_rst)
    );

    smt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .launch(launch),
        .trx(ctrl_q[B_TRX]), .stop_bit(ctrl_q[B_STP]), .count_q(count_q),
        .eng_done(eng_done), .eng_ack(eng_ack), .tx_avail(tx_avail),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_op(op_e), .cmd_rd(cmd_rd),
        .clr_start(clr_start), .clr_stop(clr_stop), .clr_master(clr_master),
        .ev_nack(ev_nack), .ev_ardy(ev_ardy), .xrdy_wr(xrdy_wr),
        .xrdy_val(xrdy_val), .txbuf_clr(txbuf_clr)
    );

    smt_status #(.NEWER_REV(NEWER_REV)) u_status (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stat_wr(stat_wr),
        .clr_bits(wr_data[2:1]), .ev_nack(ev_nack), .ev_ardy(ev_ardy),
        .xrdy_wr(xrdy_wr), .xrdy_val(xrdy_val), .trx(ctrl_q[B_TRX]),
        .rx_nonempty(rx_nonempty), .stat_q(stat_q)
    );
endmodule

// File: rtl/smt_seq_chk.sv
// Protocol checker for smt_seq, attached by bind; observes ports only.
module smt_seq_chk
    import smt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctrl_q,
    input logic [15:0] stat_q,
    input logic        cfg_reject,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        eng_done,
    input logic        eng_ack,
    input logic        txbuf_clr
);
    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == 16'h0000); // R1

    AST_REJECT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> !cmd_valid); // R3

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START && eng_done) |=> !ctrl_q[B_STT]); // R4

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done && cmd_op != OP_BYTE) |=> (cmd_valid && $stable(cmd_op))); // R4

    AST_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_START && eng_done && !eng_ack)
        |=> (stat_q[S_NACK] && !ctrl_q[B_STP] && !cmd_valid)); // R5

    AST_STOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STOP && eng_done) |=> (txbuf_clr && !ctrl_q[B_STP])); // R7

    AST_TXCLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        txbuf_clr |=> !txbuf_clr); // R7

    AST_RRDY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_q[B_TRX]) |-> !stat_q[S_RRDY]); // R10
endmodule

bind smt_seq smt_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .cfg_reject(cfg_reject), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .eng_done(eng_done), .eng_ack(eng_ack), .txbuf_clr(txbuf_clr)
);

// File: tb/smt_seq_tb.sv
// Scoreboard bench: tasks queue the expected engine commands, and an engine
// model pops and compares each command when it completes it.
module smt_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, lwr_en;
    logic [1:0]  wr_addr, lwr_addr;
    logic [15:0] wr_data, lwr_data;
    logic        eng_done, eng_ack, tx_avail, rx_nonempty;
    logic [15:0] ctrl_q, stat_q, lctrl_q, lstat_q;
    logic        sys_status, cfg_reject, cmd_valid, cmd_rd, txbuf_clr;
    logic [1:0]  cmd_op;
    logic        lsys, lrej, lvalid, lrd, ltxclr;
    logic [1:0]  lop;

    int vectors = 0;
    int fails   = 0;
    int n_txclr = 0;
    int n_rej   = 0;
    logic [2:0] exp_q[$];
    bit nack_addr = 1'b0;
    int nack_byte = -1;
    int byte_idx  = 0;

    always #4 clk = ~clk;

    smt_seq #(.NEWER_REV(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_done(eng_done), .eng_ack(eng_ack),
        .tx_avail(tx_avail), .rx_nonempty(rx_nonempty), .ctrl_q(ctrl_q),
        .stat_q(stat_q), .sys_status(sys_status), .cfg_reject(cfg_reject),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rd(cmd_rd),
        .txbuf_clr(txbuf_clr)
    );

    smt_seq #(.NEWER_REV(1'b0)) u_dut_leg (
        .clk(clk), .rst_n(rst_n), .wr_en(lwr_en), .wr_addr(lwr_addr),
        .wr_data(lwr_data), .eng_done(1'b0), .eng_ack(1'b0),
        .tx_avail(1'b0), .rx_nonempty(1'b0), .ctrl_q(lctrl_q),
        .stat_q(lstat_q), .sys_status(lsys), .cfg_reject(lrej),
        .cmd_valid(lvalid), .cmd_op(lop), .cmd_rd(lrd), .txbuf_clr(ltxclr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lwr(input logic [1:0] a, input logic [15:0] d);
        lwr_en = 1'b1; lwr_addr = a; lwr_data = d;
        @(negedge clk);
        lwr_en = 1'b0;
    endtask

    task automatic expect_cmd(input logic [1:0] op, input logic rd);
        exp_q.push_back({op, rd});
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
        chk("R6 queue drained", exp_q.size(), 0);
    endtask

    // Engine model and scoreboard monitor
    initial begin
        int lat;
        eng_done = 1'b0; eng_ack = 1'b1; lat = 0;
        forever begin
            @(negedge clk);
            if (eng_done) begin
                eng_done = 1'b0; lat = 0;
            end else if (cmd_valid) begin
                lat++;
                if (lat >= 2) begin
                    vectors++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R6 unexpected command: actual op %0d rd %0d expected none", cmd_op, cmd_rd);
                    end else begin
                        logic [2:0] e;
                        e = exp_q.pop_front();
                        if ({cmd_op, cmd_rd} !== e) begin
                            fails++;
                            $display("FAIL R4 command: actual op %0d rd %0d expected op %0d rd %0d",
                                     cmd_op, cmd_rd, e[2:1], e[0]);
                        end
                    end
                    case (cmd_op)
                        2'd1: begin eng_ack = !nack_addr; byte_idx = 0; end
                        2'd2: begin eng_ack = (byte_idx != nack_byte); byte_idx++; end
                        default: eng_ack = 1'b1;
                    endcase
                    eng_done = 1'b1;
                end
            end
        end
    end

    // Pulse counters
    initial begin
        forever begin
            @(negedge clk);
            if (txbuf_clr) n_txclr++;
            if (cfg_reject) n_rej++;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int t0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        lwr_en = 1'b0; lwr_addr = '0; lwr_data = '0;
        tx_avail = 1'b1; rx_nonempty = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ctrl", ctrl_q, 16'h0000);
        chk("R12 reset stat", stat_q, 16'h0000);
        chk("R2 reset sys_status", sys_status, 1'b0);
        chk("R4 reset cmd_valid", cmd_valid, 1'b0);

        // R1/R11: mask, newer revision keeps an enable-clear write
        wr(2'd0, 16'h8400);
        chk("R2 sys_status follows enable", sys_status, 1'b1);
        wr(2'd0, 16'h30F8);
        chk("R1 R11 masked store, no reset", ctrl_q, 16'h0080);
        chk("R2 enable cleared", sys_status, 1'b0);

        // R6/R7/R9/R13: transmit 3 bytes with stop
        rx_nonempty = 1'b1;
        wr(2'd1, 16'd3);
        expect_cmd(2'd1, 1'b0);
        repeat (3) expect_cmd(2'd2, 1'b0);
        expect_cmd(2'd3, 1'b0);
        t0 = n_txclr;
        wr(2'd0, 16'h8603);
        repeat (2) @(posedge eng_done);
        wr(2'd0, 16'h0000); // R13 busy write
        chk("R9 xrdy while bytes remain", stat_q[4], 1'b1);
        chk("R10 rrdy low in transmit", stat_q[3], 1'b0);
        settle();
        chk("R13 R4 R7 ctrl after stop", ctrl_q, 16'h8600);
        chk("R9 R7 stat after stop", stat_q, 16'h0000);
        chk("R7 txbuf_clr one pulse", n_txclr - t0, 1);

        // R8/R10: receive 2 bytes without stop
        wr(2'd1, 16'd2);
        expect_cmd(2'd1, 1'b1);
        repeat (2) expect_cmd(2'd2, 1'b1);
        wr(2'd0, 16'h8401);
        settle();
        chk("R8 master cleared", ctrl_q, 16'h8000);
        chk("R8 R10 ardy and rrdy", stat_q, 16'h000C);
        wr(2'd2, 16'h0004);
        chk("R12 w1c ardy", stat_q, 16'h0008);
        rx_nonempty = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 rrdy follows buffer", stat_q, 16'h0000);

        // R5/R12: address nack with clear on the same edge
        nack_addr = 1'b1;
        expect_cmd(2'd1, 1'b0);
        wr(2'd0, 16'h8603);
        @(posedge eng_done);
        wr(2'd2, 16'h0002);
        settle();
        nack_addr = 1'b0;
        chk("R12 set wins over clear", stat_q, 16'h0002);
        chk("R5 start and stop cleared", ctrl_q, 16'h8600);
        wr(2'd2, 16'h0002);
        chk("R12 later clear works", stat_q, 16'h0000);

        // R9: transmit byte nack on second byte
        nack_byte = 1;
        wr(2'd1, 16'd4);
        expect_cmd(2'd1, 1'b0);
        repeat (2) expect_cmd(2'd2, 1'b0);
        wr(2'd0, 16'h8601);
        settle();
        nack_byte = -1;
        chk("R9 byte nack ends transfer", stat_q, 16'h0002);
        chk("R9 master kept on byte nack", ctrl_q, 16'h8600);
        wr(2'd2, 16'h0002);

        // R3: refusals
        t0 = n_rej;
        wr(2'd0, 16'h8201);
        chk("R3 reject pulse slave", cfg_reject, 1'b1);
        wr(2'd0, 16'h8701);
        chk("R3 reject pulse extaddr", cfg_reject, 1'b1);
        settle();
        chk("R3 refused word stored", ctrl_q, 16'h8701);
        chk("R3 two rejects", n_rej - t0, 2);

        // R6: transmit waits for data
        tx_avail = 1'b0;
        wr(2'd1, 16'd1);
        expect_cmd(2'd1, 1'b0);
        wr(2'd0, 16'h8601);
        @(posedge eng_done);
        repeat (10) @(negedge clk);
        chk("R6 byte held without data", cmd_valid, 1'b0);
        expect_cmd(2'd2, 1'b0);
        tx_avail = 1'b1;
        settle();
        chk("R8 ctrl after tx", ctrl_q, 16'h8200);
        chk("R8 R9 stat after tx", stat_q, 16'h0004);
        wr(2'd2, 16'h0004);

        // R6/R7: zero count with stop
        wr(2'd1, 16'd0);
        expect_cmd(2'd1, 1'b0);
        expect_cmd(2'd3, 1'b0);
        t0 = n_txclr;
        wr(2'd0, 16'h8603);
        settle();
        chk("R7 zero count stop", ctrl_q, 16'h8600);
        chk("R7 zero count txbuf_clr", n_txclr - t0, 1);

        // R12: ardy set collides with clear
        wr(2'd1, 16'd1);
        expect_cmd(2'd1, 1'b1);
        expect_cmd(2'd2, 1'b1);
        wr(2'd0, 16'h8401);
        repeat (2) @(posedge eng_done);
        wr(2'd2, 16'h0004);
        settle();
        chk("R12 ardy set wins", stat_q, 16'h0004);

        // R12: soft reset through system-config
        wr(2'd3, 16'h0001);
        chk("R12 no reset without bit 1", ctrl_q, 16'h8000);
        wr(2'd3, 16'h0002);
        chk("R12 soft reset ctrl", ctrl_q, 16'h0000);
        chk("R12 soft reset stat", stat_q, 16'h0000);
        expect_cmd(2'd1, 1'b1);
        wr(2'd0, 16'h8401);
        settle();
        chk("R12 count cleared by soft reset", stat_q, 16'h0004);

        // R11/R12: legacy revision
        lwr(2'd0, 16'h8400);
        chk("R1 legacy store", lctrl_q, 16'h8400);
        lwr(2'd3, 16'h0002);
        chk("R12 legacy sysc ignored", lctrl_q, 16'h8400);
        lwr(2'd0, 16'h0480);
        chk("R11 legacy enable-clear reset", lctrl_q, 16'h0000);
        chk("R11 legacy stat reset", lstat_q, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule